// File: doc/BRIEF.md
# Host Handshake Pin Multiplexer for an Upper Port Nibble

This block sits between the port output latch of a small slave controller and four of its port pins. After reset every pin simply shows its latch bit. Two one-cycle strobes, issued by the controller's instruction logic, switch pin groups into handshake roles. Flag mode turns one pin into an output-full indication and a second into an input-ready indication for the host. DMA mode turns a third pin into a DMA request and the fourth into a DMA acknowledge input.

In flag mode each latch bit acts as the per-pin enable: a latch bit of 1 lets the indication through, a 0 holds the pin low. In DMA mode, writing a 1 into the request bit of the latch raises the request. The request stays up until the host completes an acknowledged read or write, or the DMA-mode strobe is issued again. While acknowledge is asserted, the block selects the data buffer registers for the host and forces the data register (not the command register) regardless of the host's chip select and address. Both modes stay on until the next reset. The analog quasi-bidirectional drive of the real pins is left to the pad logic.

Top module: `hs_pin_mux`

## Requirements
- R1: While reset is held, pin_o reads all ones (the latch resets to all ones), both modes are off, and bus_sel_o and bus_a0_o are 0.
- R2: With no mode on, a latch write puts latch_wdata_i on pin_o from the next cycle, every bit unchanged.
- R3: In flag mode, pin bit 4 equals obf_i whenever latch bit 4 holds 1.
- R4: In flag mode, pin bit 5 equals the inverse of ibf_i whenever latch bit 5 holds 1.
- R5: In flag mode, a latch bit 4 or bit 5 holding 0 keeps that pin at 0 whatever obf_i and ibf_i are.
- R6: In DMA mode, a latch write with bit 6 set raises the request on pin bit 6 from the next cycle; a write with bit 6 clear leaves the request unchanged.
- R7: The request drops in the cycle after acknowledge (dack_n_i low, DMA mode on) coincides with host_rd_i or host_wr_i.
- R8: The request drops in the cycle after the DMA-mode strobe is issued again.
- R9: While DMA mode is on and dack_n_i is low, bus_sel_o is 1 and bus_a0_o is 0 regardless of host_cs_i and host_a0_i; otherwise bus_sel_o follows host_cs_i and bus_a0_o follows host_a0_i.
- R10: With DMA mode off, dack_n_i has no effect: bus selection follows host_cs_i and pin bit 7 shows its latch bit.
- R11: Each mode, once on, stays on through repeated strobes until reset; after reset the pins return to plain latch behaviour.
- R12: Entering DMA mode starts with the request low (pin bit 6 reads 0 even with latch bit 6 at 1), pin bit 7 reads 1 (released as an input), and a request can be set only while DMA mode is on.
- R13: A latch write setting the request in the same cycle as an acknowledged transfer leaves the request high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flag_en_stb_i | input | 1 | One-cycle strobe turning flag mode on |
| dma_en_stb_i | input | 1 | One-cycle strobe turning DMA mode on and clearing the request |
| latch_we_i | input | 1 | Port latch write enable |
| latch_wdata_i | input | PORT_W | Port latch write data |
| obf_i | input | 1 | Output buffer full status |
| ibf_i | input | 1 | Input buffer full status |
| host_cs_i | input | 1 | Host chip select, active high |
| host_a0_i | input | 1 | Host register address (0 data, 1 command) |
| host_rd_i | input | 1 | Host read in progress, active high |
| host_wr_i | input | 1 | Host write in progress, active high |
| dack_n_i | input | 1 | Level seen on the acknowledge pin, active low |
| pin_o | output | PORT_W | Values driven toward the port pins |
| bus_sel_o | output | 1 | Data buffer registers selected for the host |
| bus_a0_o | output | 1 | Register address used for the host access |

## Verification
The bench builds the block with its default parameters: an eight-bit port with the output-full, input-ready, request and acknowledge roles on bits 4, 5, 6 and 7. That placement keeps all four role pins and the plain lower nibble in one observable byte, so each expected value is a whole pin_o word. The run walks through plain mode, flag mode with every latch/status combination that matters, and DMA mode with request set, cleared by acknowledged reads and writes, cleared by a repeated strobe and kept by a coincident set. It also covers a mid-run reset that shows the modes do not survive it.

// File: rtl/hs_pkg.sv
package hs_pkg;
    localparam int unsigned HS_PORT_W   = 8;
    localparam int unsigned HS_OBF_BIT  = 4;
    localparam int unsigned HS_IBF_BIT  = 5;
    localparam int unsigned HS_DRQ_BIT  = 6;
    localparam int unsigned HS_DACK_BIT = 7;

    typedef struct packed {
        logic flag_en;
        logic dma_en;
    } hs_mode_t;
endpackage

// File: rtl/hs_port_state.sv
module hs_port_state
    import hs_pkg::*;
#(
    parameter int unsigned PORT_W = HS_PORT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flag_stb_i,
    input  logic              dma_stb_i,
    input  logic              we_i,
    input  logic [PORT_W-1:0] wdata_i,
    output logic [PORT_W-1:0] latch_o,
    output hs_mode_t          mode_o
);
    typedef struct packed {
        logic [PORT_W-1:0] latch;
        hs_mode_t          mode;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we_i)       st_d.latch        = wdata_i;
        if (flag_stb_i) st_d.mode.flag_en = 1'b1;
        if (dma_stb_i)  st_d.mode.dma_en  = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.latch <= '1;
            st_q.mode  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign latch_o = st_q.latch;
    assign mode_o  = st_q.mode;

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.mode.flag_en |=> st_q.mode.flag_en); // R11
    AST_DMA_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.mode.dma_en |=> st_q.mode.dma_en); // R11
endmodule

// File: rtl/hs_drq_ctrl.sv
module hs_drq_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic dma_en_i,
    input  logic set_i,
    input  logic restrobe_i,
    input  logic xfer_i,
    output logic drq_o
);
    typedef struct packed {
        logic drq;
    } drq_state_t;

    drq_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (restrobe_i || xfer_i) st_d.drq = 1'b0;
        if (dma_en_i && set_i)    st_d.drq = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign drq_o = st_q.drq;

    AST_DRQ_ACK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_i && !set_i) |=> !drq_o); // R7
    AST_DRQ_RESTROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (restrobe_i && !set_i) |=> !drq_o); // R8
    AST_DRQ_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_en_i && set_i) |=> drq_o); // R13
    AST_DRQ_NEEDS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_en_i |-> !drq_o); // R12
endmodule

// File: rtl/hs_bus_select.sv
module hs_bus_select (
    input  logic dma_en_i,
    input  logic dack_n_i,
    input  logic cs_i,
    input  logic a0_i,
    output logic dack_act_o,
    output logic sel_o,
    output logic a0_o
);
    always_comb begin
        dack_act_o = dma_en_i && !dack_n_i;
        sel_o      = cs_i || dack_act_o;
        a0_o       = dack_act_o ? 1'b0 : a0_i;
    end
endmodule

// File: rtl/hs_pin_mux.sv
module hs_pin_mux
    import hs_pkg::*;
#(
    parameter int unsigned PORT_W   = HS_PORT_W,
    parameter int unsigned OBF_BIT  = HS_OBF_BIT,
    parameter int unsigned IBF_BIT  = HS_IBF_BIT,
    parameter int unsigned DRQ_BIT  = HS_DRQ_BIT,
    parameter int unsigned DACK_BIT = HS_DACK_BIT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flag_en_stb_i,
    input  logic              dma_en_stb_i,
    input  logic              latch_we_i,
    input  logic [PORT_W-1:0] latch_wdata_i,
    input  logic              obf_i,
    input  logic              ibf_i,
    input  logic              host_cs_i,
    input  logic              host_a0_i,
    input  logic              host_rd_i,
    input  logic              host_wr_i,
    input  logic              dack_n_i,
    output logic [PORT_W-1:0] pin_o,
    output logic              bus_sel_o,
    output logic              bus_a0_o
);
    logic [PORT_W-1:0] latch_q;
    hs_mode_t          mode_q;
    logic              drq_q;
    logic              dack_act;
    logic              xfer_done;
    logic              drq_set;

    hs_port_state #(.PORT_W(PORT_W)) u_state (
        .clk        (clk),
        .rst_n      (rst_n),
        .flag_stb_i (flag_en_stb_i),
        .dma_stb_i  (dma_en_stb_i),
        .we_i       (latch_we_i),
        .wdata_i    (latch_wdata_i),
        .latch_o    (latch_q),
        .mode_o     (mode_q)
    );

    hs_bus_select u_bus (
        .dma_en_i   (mode_q.dma_en),
        .dack_n_i   (dack_n_i),
        .cs_i       (host_cs_i),
        .a0_i       (host_a0_i),
        .dack_act_o (dack_act),
        .sel_o      (bus_sel_o),
        .a0_o       (bus_a0_o)
    );

    assign xfer_done = dack_act && (host_rd_i || host_wr_i);
    assign drq_set   = latch_we_i && latch_wdata_i[DRQ_BIT];

    hs_drq_ctrl u_drq (
        .clk        (clk),
        .rst_n      (rst_n),
        .dma_en_i   (mode_q.dma_en),
        .set_i      (drq_set),
        .restrobe_i (dma_en_stb_i),
        .xfer_i     (xfer_done),
        .drq_o      (drq_q)
    );

    always_comb begin
        pin_o = latch_q;
        if (mode_q.flag_en) begin
            pin_o[OBF_BIT] = latch_q[OBF_BIT] & obf_i;
            pin_o[IBF_BIT] = latch_q[IBF_BIT] & ~ibf_i;
        end
        if (mode_q.dma_en) begin
            pin_o[DRQ_BIT]  = drq_q;
            pin_o[DACK_BIT] = 1'b1;
        end
    end

    AST_OBF_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q.flag_en && latch_q[OBF_BIT]) |-> (pin_o[OBF_BIT] == obf_i)); // R3
    AST_IBF_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q.flag_en && latch_q[IBF_BIT]) |-> (pin_o[IBF_BIT] != ibf_i)); // R4
    AST_FLAG_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q.flag_en && !latch_q[OBF_BIT]) |-> !pin_o[OBF_BIT]); // R5
    AST_DACK_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q.dma_en && !dack_n_i) |-> (bus_sel_o && !bus_a0_o)); // R9
    AST_NO_DMA_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_q.dma_en |-> (bus_sel_o == host_cs_i)); // R10
endmodule

// File: tb/hs_pin_mux_tb.sv
module hs_pin_mux_tb;
    localparam int CLK_PERIOD = 10;
    localparam int W = 8;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic rst_n, flag_stb, dma_stb, we, obf, ibf, cs, a0, rd, wr, dack_n;
    logic [W-1:0] wdata;
    logic [W-1:0] pin_o;
    logic bus_sel_o, bus_a0_o;

    hs_pin_mux u_dut (
        .clk(clk), .rst_n(rst_n), .flag_en_stb_i(flag_stb), .dma_en_stb_i(dma_stb),
        .latch_we_i(we), .latch_wdata_i(wdata), .obf_i(obf), .ibf_i(ibf),
        .host_cs_i(cs), .host_a0_i(a0), .host_rd_i(rd), .host_wr_i(wr),
        .dack_n_i(dack_n), .pin_o(pin_o), .bus_sel_o(bus_sel_o), .bus_a0_o(bus_a0_o)
    );

    typedef struct packed {
        logic [W-1:0] pins;
        logic         sel;
        logic         a0;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    int checks = 0;
    int errors = 0;
    bit done = 0;

    // driver side: push the expectation for the next falling edge, then advance
    task automatic expect_next(input logic [W-1:0] p, input logic s, input logic a,
                               input string tag);
        exp_t e;
        e.pins = p; e.sel = s; e.a0 = a;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        #1;
    endtask

    // monitor side: compare away from the active edge
    initial begin
        forever begin
            exp_t  e;
            string t;
            @(negedge clk);
            if (exp_q.size() > 0) begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if (pin_o !== e.pins || bus_sel_o !== e.sel || bus_a0_o !== e.a0) begin
                    errors++;
                    $display("FAIL %s: got pins=%h sel=%b a0=%b expected pins=%h sel=%b a0=%b",
                             t, pin_o, bus_sel_o, bus_a0_o, e.pins, e.sel, e.a0);
                end
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got hung run expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 0; flag_stb = 0; dma_stb = 0; we = 0; wdata = '0;
        obf = 0; ibf = 0; cs = 0; a0 = 0; rd = 0; wr = 0; dack_n = 1;
        @(negedge clk); #1;
        expect_next(8'hFF, 0, 0, "R1 reset state");

        rst_n = 1; we = 1; wdata = 8'h5A;
        expect_next(8'h5A, 0, 0, "R2 plain latch write");
        we = 0;

        dack_n = 0; rd = 1;
        expect_next(8'h5A, 0, 0, "R10 acknowledge ignored without DMA mode");
        dack_n = 1; rd = 0;

        we = 1; wdata = 8'hFF;
        expect_next(8'hFF, 0, 0, "R2 second latch write");
        we = 0;

        flag_stb = 1;
        expect_next(8'hEF, 0, 0, "R3 flag mode obf low");
        flag_stb = 0;

        obf = 1; ibf = 1;
        expect_next(8'hDF, 0, 0, "R4 flag mode ibf high");

        we = 1; wdata = 8'hCF; ibf = 0;
        expect_next(8'hCF, 0, 0, "R5 latch zero gates flag pins");
        we = 0;

        we = 1; wdata = 8'hFF; flag_stb = 1;
        expect_next(8'hFF, 0, 0, "R11 repeated flag strobe");
        we = 0; flag_stb = 0;

        obf = 0;
        expect_next(8'hEF, 0, 0, "R11 flag mode still on");
        obf = 1;

        dma_stb = 1;
        expect_next(8'hBF, 0, 0, "R12 entering DMA mode");
        dma_stb = 0;

        we = 1; wdata = 8'hBF;
        expect_next(8'hBF, 0, 0, "R6 write with bit 6 clear");
        wdata = 8'hFF;
        expect_next(8'hFF, 0, 0, "R6 write with bit 6 set");
        we = 0;

        dack_n = 0; rd = 1; a0 = 1;
        expect_next(8'hBF, 1, 0, "R7 R9 acknowledged read");
        dack_n = 1; rd = 0; a0 = 0;

        we = 1; wdata = 8'hFF;
        expect_next(8'hFF, 0, 0, "R6 request set again");
        we = 0;

        dack_n = 0; wr = 1;
        expect_next(8'hBF, 1, 0, "R7 acknowledged write");
        dack_n = 1; wr = 0;

        we = 1; wdata = 8'hFF;
        expect_next(8'hFF, 0, 0, "R6 request set before restrobe");
        we = 0;

        dma_stb = 1;
        expect_next(8'hBF, 0, 0, "R8 repeated DMA strobe clears request");
        dma_stb = 0;

        we = 1; wdata = 8'hFF; dack_n = 0; rd = 1;
        expect_next(8'hFF, 1, 0, "R13 set beats coincident transfer");
        we = 0; dack_n = 1; rd = 0;

        cs = 1; a0 = 1;
        expect_next(8'hFF, 1, 1, "R9 plain host select passes through");

        dack_n = 0; wr = 1;
        expect_next(8'hBF, 1, 0, "R9 acknowledge overrides host address");
        dack_n = 1; wr = 0; cs = 0; a0 = 0;

        rst_n = 0;
        expect_next(8'hFF, 0, 0, "R11 reset mid-run");

        rst_n = 1; we = 1; wdata = 8'h4F;
        expect_next(8'h4F, 0, 0, "R11 plain mode after reset");
        we = 0;

        dack_n = 0; rd = 1;
        expect_next(8'h4F, 0, 0, "R10 acknowledge ignored after reset");
        dack_n = 1; rd = 0;

        @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule